// File: doc/BRIEF.md
# Bridge Delayed-Read and Prefetch Controller

This block sits on the target side of a PCI-to-PCI style bridge. It decodes the command of each address phase and gives back a disposition one clock later. Memory writes are accepted. Memory reads are told to retry and are captured as delayed transactions. I/O, configuration and every other command end in a master abort.

Each captured read holds the address, the command and the sampled parity. It waits in a small first-in first-out queue. For each read the block works out how many double words an upstream fetch may cover. A plain read fetches one double word. A read-line fetches one cache line. A read-multiple prefetches a larger burst, unless a configuration bit turns prefetch off. Every fetch is clipped at the end of the 4 KB page that holds its start address.

The queue head is offered upstream on a ready/valid handshake, with its address, command and length.

Top module: `bridge_dr_ctrl`

## Requirements
- R1: A memory read (command 0x6, 0xC or 0xE) with good parity that is not already queued, arriving while the queue has room, gets disposition retry (code 1). It is stored as one entry holding its address and command.
- R2: I/O read and I/O write (0x2, 0x3) get disposition master abort (code 2) and are never queued.
- R3: Configuration read and write (0xA, 0xB) get master abort (code 2) and are never queued.
- R4: A memory read (0x6) has an upstream length of exactly 1 double word.
- R5: A memory read line (0xE) has length min(8, L). L = 1024 - addr[11:2] is the number of double words left in the 4 KB page.
- R6: A memory read multiple (0xC) has length min(16, L) while bit 4 of the 16-bit configuration input is 0.
- R7: A memory read multiple has length 1 while bit 4 of the configuration input is 1. The bit is sampled when the entry is stored.
- R8: Parity is good when req_par_i equals the XOR of all bits of req_addr_i and req_cmd_i. A memory read with bad parity raises perr_o with its disposition, gets retry, and is not queued.
- R9: With 4 entries already queued, a new read gets retry and is not queued.
- R10: A read whose address and command both match a queued entry gets retry and adds no entry.
- R11: Entries leave in arrival order, one per cycle in which up_valid_o and up_ready_i are both high. While up_valid_o is high and up_ready_i is low, the head's fields hold steady.
- R12: Memory write (0x7) and memory write and invalidate (0xF) get accept (code 0). Every command not named above gets master abort. None of these is queued.
- R13: After reset, resp_valid_o, perr_o and up_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Address phase present this cycle |
| req_addr_i | input | 32 | Address of the request |
| req_cmd_i | input | 4 | PCI command code |
| req_par_i | input | 1 | Parity sampled with the address |
| cfg_ctl_i | input | 16 | Configuration register; bit 4 disables prefetch |
| resp_valid_o | output | 1 | Disposition valid, one cycle after the request |
| resp_code_o | output | 2 | 0 accept, 1 retry, 2 master abort |
| perr_o | output | 1 | Parity error on a read, paired with the disposition |
| up_valid_o | output | 1 | Upstream request available |
| up_ready_i | input | 1 | Upstream side takes the request |
| up_addr_o | output | 32 | Start address of the upstream fetch |
| up_cmd_o | output | 4 | Command of the upstream fetch |
| up_len_o | output | 11 | Fetch length in double words |

## Verification
The hardest case to reach is a request that meets a full queue and is also a duplicate of a queued entry, while its parity is also checked. That case needs four distinct reads to be held back from the upstream side. Addresses are drawn from a small pool that includes spots a few double words short of a page end. Drain steps are randomly interleaved, so the queue keeps filling to its limit and repeats come up often. Directed cases add the exact page-edge lengths, the prefetch-disable bit and forced parity errors.

// File: rtl/bridge_dr_pkg.sv
package bridge_dr_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned LEN_W  = 11;

  localparam logic [CMD_W-1:0] CMD_IO_RD  = 4'h2;
  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'h3;
  localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'h6;
  localparam logic [CMD_W-1:0] CMD_MEM_WR = 4'h7;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'hA;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'hB;
  localparam logic [CMD_W-1:0] CMD_MRM    = 4'hC;
  localparam logic [CMD_W-1:0] CMD_MRL    = 4'hE;
  localparam logic [CMD_W-1:0] CMD_MWI    = 4'hF;

  typedef enum logic [1:0] {
    DISP_ACCEPT = 2'd0,
    DISP_RETRY  = 2'd1,
    DISP_ABORT  = 2'd2
  } disp_e;

  typedef enum logic [1:0] {
    K_MEMRD,
    K_MEMWR,
    K_ABORT
  } kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic              par;
    logic [LEN_W-1:0]  len;
  } dr_entry_t;
endpackage

// File: rtl/bdr_cmd_decode.sv
module bdr_cmd_decode
  import bridge_dr_pkg::*;
#(
  parameter int unsigned LINE_DW   = 8,
  parameter int unsigned PF_MAX_DW = 16
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             pf_dis_i,
  output kind_e            kind_o,
  output logic [LEN_W-1:0] nom_len_o
);
  always_comb begin
    kind_o    = K_ABORT;
    nom_len_o = '0;
    unique case (cmd_i)
      CMD_MEM_RD: begin
        kind_o    = K_MEMRD;
        nom_len_o = LEN_W'(1);
      end
      CMD_MRL: begin
        kind_o    = K_MEMRD;
        nom_len_o = LEN_W'(LINE_DW);
      end
      CMD_MRM: begin
        kind_o    = K_MEMRD;
        nom_len_o = pf_dis_i ? LEN_W'(1) : LEN_W'(PF_MAX_DW);
      end
      CMD_MEM_WR, CMD_MWI: kind_o = K_MEMWR;
      default:             kind_o = K_ABORT; // io, cfg, special, reserved
    endcase
  end
endmodule

// File: rtl/bdr_len_clip.sv
module bdr_len_clip
  import bridge_dr_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  nom_len_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam int unsigned DW_IDX_W = PAGE_BITS - 2;
  localparam int unsigned PAGE_DW  = 1 << DW_IDX_W;
  localparam int unsigned LEFT_W   = DW_IDX_W + 1;

  logic [LEFT_W-1:0] left_dw;

  always_comb begin
    left_dw = LEFT_W'(PAGE_DW) - LEFT_W'(addr_i[PAGE_BITS-1:2]);
    if (LEFT_W'(nom_len_i) > left_dw) len_o = LEN_W'(left_dw);
    else                              len_o = nom_len_i;
  end
endmodule

// File: rtl/bdr_req_queue.sv
module bdr_req_queue
  import bridge_dr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  dr_entry_t         push_data_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] match_addr_i,
  input  logic [CMD_W-1:0]  match_cmd_i,
  output logic              hit_o,
  output logic              full_o,
  output logic              empty_o,
  output dr_entry_t         head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  dr_entry_t        mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_v;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_ptr_q];
  assign hit_o   = |hit_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign hit_v[i] = vld_q[i] && (mem_q[i].addr == match_addr_i)
                      && (mem_q[i].cmd == match_cmd_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else if (push_i && wr_ptr_q == PTR_W'(i)) begin
        mem_q[i] <= push_data_i;
        vld_q[i] <= 1'b1;
      end else if (pop_i && rd_ptr_q == PTR_W'(i)) begin
        vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R11
  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vld_q) == int'(cnt_q)); // R11
endmodule

// File: rtl/bridge_dr_ctrl.sv
module bridge_dr_ctrl
  import bridge_dr_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned LINE_DW    = 8,
  parameter int unsigned PF_MAX_DW  = 16,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned PF_DIS_BIT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_addr_i,
  input  logic [3:0]  req_cmd_i,
  input  logic        req_par_i,
  input  logic [15:0] cfg_ctl_i,
  output logic        resp_valid_o,
  output logic [1:0]  resp_code_o,
  output logic        perr_o,
  output logic        up_valid_o,
  input  logic        up_ready_i,
  output logic [31:0] up_addr_o,
  output logic [3:0]  up_cmd_o,
  output logic [10:0] up_len_o
);
  localparam int unsigned PAGE_DW = 1 << (PAGE_BITS - 2);

  kind_e            kind;
  logic [LEN_W-1:0] nom_len, clip_len;
  logic             par_ok, is_rd, q_hit, q_full, q_empty, enq, deq;
  dr_entry_t        new_ent, head;
  disp_e            disp_d;

  bdr_cmd_decode #(.LINE_DW(LINE_DW), .PF_MAX_DW(PF_MAX_DW)) u_dec (
    .cmd_i     (req_cmd_i),
    .pf_dis_i  (cfg_ctl_i[PF_DIS_BIT]),
    .kind_o    (kind),
    .nom_len_o (nom_len)
  );

  bdr_len_clip #(.PAGE_BITS(PAGE_BITS)) u_clip (
    .addr_i    (req_addr_i),
    .nom_len_i (nom_len),
    .len_o     (clip_len)
  );

  assign par_ok = (req_par_i == ^{req_addr_i, req_cmd_i});
  assign is_rd  = (kind == K_MEMRD);
  assign enq    = req_valid_i && is_rd && par_ok && !q_hit && !q_full;

  assign new_ent.addr = req_addr_i;
  assign new_ent.cmd  = req_cmd_i;
  assign new_ent.par  = req_par_i;
  assign new_ent.len  = clip_len;

  bdr_req_queue #(.DEPTH(DEPTH)) u_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (enq),
    .push_data_i  (new_ent),
    .pop_i        (deq),
    .match_addr_i (req_addr_i),
    .match_cmd_i  (req_cmd_i),
    .hit_o        (q_hit),
    .full_o       (q_full),
    .empty_o      (q_empty),
    .head_o       (head)
  );

  always_comb begin
    unique case (kind)
      K_MEMRD: disp_d = DISP_RETRY;
      K_MEMWR: disp_d = DISP_ACCEPT;
      default: disp_d = DISP_ABORT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_code_o  <= DISP_ACCEPT;
      perr_o       <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_code_o  <= req_valid_i ? disp_d : DISP_ACCEPT;
      perr_o       <= req_valid_i && is_rd && !par_ok;
    end
  end

  assign up_valid_o = !q_empty;
  assign deq        = up_valid_o && up_ready_i;
  assign up_addr_o  = head.addr;
  assign up_cmd_o   = head.cmd;
  assign up_len_o   = head.len;

  AST_IO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_cmd_i == CMD_IO_RD || req_cmd_i == CMD_IO_WR)
    |=> resp_valid_o && resp_code_o == DISP_ABORT); // R2
  AST_CFG_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_cmd_i == CMD_CFG_RD || req_cmd_i == CMD_CFG_WR)
    |=> resp_code_o == DISP_ABORT); // R3
  AST_RD_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_cmd_i == CMD_MEM_RD || req_cmd_i == CMD_MRM || req_cmd_i == CMD_MRL)
    |=> resp_code_o == DISP_RETRY); // R1
  AST_PERR_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> resp_valid_o && resp_code_o == DISP_RETRY); // R8
  AST_PAGE_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o |-> (32'(up_addr_o[PAGE_BITS-1:2]) + 32'(up_len_o)) <= PAGE_DW); // R5
  AST_LEN_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o |-> up_len_o != '0 && up_len_o <= LEN_W'(PF_MAX_DW)); // R6
  AST_MR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o && up_cmd_o == CMD_MEM_RD |-> up_len_o == LEN_W'(1)); // R4
  AST_UP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_o && !up_ready_i |=> up_valid_o && $stable(up_addr_o)
    && $stable(up_len_o) && $stable(up_cmd_o)); // R11
endmodule

// File: tb/sim_bridge_dr_ctrl.sv
module sim_bridge_dr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        req_par = 1'b0;
  logic [15:0] cfg = '0;
  logic        resp_valid, perr, up_valid;
  logic [1:0]  resp_code;
  logic        up_ready = 1'b0;
  logic [31:0] up_addr;
  logic [3:0]  up_cmd;
  logic [10:0] up_len;

  int total = 0;
  int bad = 0;

  logic [31:0] m_addr [QD];
  logic [3:0]  m_cmd  [QD];
  int          m_len  [QD];
  int          m_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_dr_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_cmd_i(req_cmd), .req_par_i(req_par), .cfg_ctl_i(cfg),
    .resp_valid_o(resp_valid), .resp_code_o(resp_code), .perr_o(perr),
    .up_valid_o(up_valid), .up_ready_i(up_ready), .up_addr_o(up_addr),
    .up_cmd_o(up_cmd), .up_len_o(up_len)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_read(logic [3:0] c);
    return c == 4'h6 || c == 4'hC || c == 4'hE;
  endfunction

  function automatic int exp_code(logic [3:0] c);
    if (is_read(c)) return 1;
    if (c == 4'h7 || c == 4'hF) return 0;
    return 2;
  endfunction

  function automatic int exp_len(logic [31:0] a, logic [3:0] c, bit pfd);
    int left = 1024 - int'(a[11:2]);
    int nom = (c == 4'h6) ? 1 : (c == 4'hE) ? 8 : (pfd ? 1 : 16);
    return (nom < left) ? nom : left;
  endfunction

  // drive one address phase; checks disposition and updates the model
  task automatic do_req(input logic [31:0] a, input logic [3:0] c, input bit bad_par, input string tag);
    bit good = !bad_par;
    bit hit = 0;
    bit ex_perr;
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a && m_cmd[i] == c) hit = 1;
    req_addr  = a;
    req_cmd   = c;
    req_par   = (^{a, c}) ^ bad_par;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ex_perr = is_read(c) && !good;
    chk(resp_valid === 1'b1, tag, resp_valid, 1);
    chk(resp_code === 2'(exp_code(c)), tag, resp_code, exp_code(c));
    chk(perr === ex_perr, tag, perr, ex_perr);
    if (is_read(c) && good && !hit && m_n < QD) begin
      m_addr[m_n] = a;
      m_cmd[m_n]  = c;
      m_len[m_n]  = exp_len(a, c, cfg[4]);
      m_n++;
    end
  endtask

  task automatic do_drain(input string tag);
    chk(up_valid === (m_n != 0), tag, up_valid, m_n != 0);
    if (m_n != 0) begin
      chk(up_addr === m_addr[0], tag, up_addr, m_addr[0]);
      chk(up_cmd === m_cmd[0], tag, up_cmd, m_cmd[0]);
      chk(int'(up_len) == m_len[0], tag, up_len, m_len[0]);
      up_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      up_ready = 1'b0;
      for (int i = 1; i < m_n; i++) begin
        m_addr[i-1] = m_addr[i];
        m_cmd[i-1]  = m_cmd[i];
        m_len[i-1]  = m_len[i];
      end
      m_n--;
    end
  endtask

  task automatic drain_all(input string tag);
    while (m_n != 0) do_drain(tag);
    do_drain(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    logic [3:0]  cmds [10];
    pool = '{32'h1000_0FFC, 32'h1000_0FE0, 32'h2000_0FF8, 32'h3000_0000,
             32'h3000_0040, 32'h4000_0FC4, 32'h5000_0800, 32'h6000_0FF0};
    cmds = '{4'h6, 4'hC, 4'hE, 4'hC, 4'h2, 4'h3, 4'hA, 4'hB, 4'h7, 4'h1};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(resp_valid === 1'b0, "R13", resp_valid, 0);
    chk(perr === 1'b0, "R13", perr, 0);
    chk(up_valid === 1'b0, "R13", up_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R5 / R6 page-edge lengths
    do_req(32'h1000_0FFC, 4'hC, 0, "R6");
    do_req(32'h1000_0FE0, 4'hC, 0, "R6");
    do_req(32'h2000_0FF8, 4'hE, 0, "R5");
    do_req(32'h3000_0100, 4'h6, 0, "R4");
    drain_all("R11");
    // R7 prefetch disabled
    cfg = 16'h0010;
    do_req(32'h3000_0000, 4'hC, 0, "R7");
    cfg = 16'h0000;
    do_req(32'h3000_0000, 4'hE, 0, "R5");
    drain_all("R7");
    // R2 / R3 / R12 abort and accept, nothing queued
    do_req(32'h0000_1000, 4'h2, 0, "R2");
    do_req(32'h0000_1004, 4'h3, 0, "R2");
    do_req(32'h0000_2000, 4'hA, 0, "R3");
    do_req(32'h0000_2004, 4'hB, 1, "R3");
    do_req(32'h0000_3000, 4'h7, 0, "R12");
    do_req(32'h0000_3000, 4'hF, 0, "R12");
    do_req(32'h0000_3000, 4'h4, 0, "R12");
    do_drain("R2");
    // R8 bad parity
    do_req(32'h7000_0000, 4'h6, 1, "R8");
    do_drain("R8");
    // R10 duplicate, R9 full
    do_req(32'h7000_0010, 4'hC, 0, "R1");
    do_req(32'h7000_0010, 4'hC, 0, "R10");
    do_req(32'h7000_0010, 4'hE, 0, "R10");
    do_req(32'h7000_0020, 4'h6, 0, "R1");
    do_req(32'h7000_0030, 4'h6, 0, "R1");
    do_req(32'h7000_0040, 4'h6, 0, "R9");
    do_req(32'h7000_0050, 4'hC, 0, "R9");
    drain_all("R9");

    // constrained random mix
    for (int s = 0; s < 600; s++) begin
      int r = $urandom_range(0, 9);
      if (r < 3) begin
        do_drain("R11");
      end else begin
        logic [31:0] a = pool[$urandom_range(0, 7)];
        logic [3:0]  c = cmds[$urandom_range(0, 9)];
        cfg = ($urandom_range(0, 3) == 0) ? 16'h0010 : 16'h0000;
        do_req(a, c, $urandom_range(0, 15) == 0, "R1");
      end
    end
    drain_all("R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule